// File: doc/BRIEF.md
# CL0s Exit Handshake Controller

This block runs the initiating side of a link port's return from the CL0s low-power state to the active CL0 state. A wake request is accepted only when this port was the one that put the link into CL0s, and that ownership is recorded when the low-power entry is taken. An accepted wake starts with a low-frequency periodic signaling (LFPS) burst of fixed length. The controller then follows the partner's CL0s exit ordered sets. Each expected phase code moves it on to the next training-sequence descriptor, from TS1 to TS4.

TS4 is sent repeatedly with a counter field that counts down to Fh. Once the TS4 that carries Fh has gone out, the port is back in CL0 and the FEC encoder, scrambler and pre-coding enables come on again. The transmit equalizer preset is frozen for the whole time the port is outside CL0, so the exit never renegotiates it. If a phase does not arrive within a programmable number of cycles, the controller falls back to CL0s and flags an error. Line signaling and symbol coding sit outside the block: phases arrive as event inputs, and training sequences leave as descriptors acknowledged by a per-sequence pulse.

Top module: `cl0s_wake_ctrl`

## Requirements
- R1: After reset the controller is in CL0: `in_cl0`, `fec_en`, `scr_en` and `precode_en` are 1, and `lfps_tx`, `ts_valid`, `exit_rej` and `exit_err` are 0.
- R2: A `lp_enter` pulse in CL0 moves the controller to CL0s on the next cycle and records `lp_enter_own` as ownership. The three datapath enables are 0 in every cycle outside CL0.
- R3: An `exit_req` in CL0s without ownership is rejected. `exit_rej` is 1 for exactly the next cycle, no LFPS is sent and the state stays CL0s.
- R4: An `exit_req` in CL0s with ownership raises `lfps_tx` from the next cycle for exactly LFPS_LEN cycles. `ts_valid` is 0 while `lfps_tx` is 1.
- R5: Phase codes are 4 bits, high trit in [3:2] and low trit in [1:0]: 00t=4'h0, 01t=4'h1, 02t=4'h2, 10t=4'h4. After the LFPS, the expected phases in that order select the descriptors TS1, TS2, TS3 and TS4 (`ts_kind` 0, 1, 2, 3), each valid from the cycle after its phase.
- R6: A phase event that is not the expected next code is ignored. The same holds for any phase before the LFPS ends or during TS4. `ts_valid` and `ts_kind` are unchanged afterwards.
- R7: In TS4, `ts_cnt` starts at TS4_START (default 19) and drops by one after each `ts_sent`. `ts_last` is 1 exactly when `ts_cnt` is Fh. For TS1 to TS3, `ts_cnt` is 0 and `ts_sent` has no effect.
- R8: A `ts_sent` while TS4 carries Fh returns the controller to CL0 on the next cycle, with `ts_valid` 0 and all three enables 1. CL0 is entered in no other way after reset.
- R9: When the controller has spent `timeout_lim`+1 cycles waiting for one phase without receiving it, it returns to CL0s. `exit_err` is 1 for that one cycle, and `lfps_tx` and `ts_valid` are 0.
- R10: `tx_preset` follows `ffe_preset_in` with one cycle of delay while in CL0. It holds the value taken on the `lp_enter` cycle until CL0 is reached again, whatever `ffe_preset_in` does meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_enter | input | 1 | Pulse: link enters CL0s (taken in CL0 only) |
| lp_enter_own | input | 1 | This port initiated the CL0s entry, sampled with lp_enter |
| exit_req | input | 1 | Pulse: request to leave CL0s |
| phase_valid | input | 1 | A partner CL0s exit ordered set was received |
| phase_code | input | 4 | Phase of that ordered set, two trits |
| ts_sent | input | 1 | Pulse: one instance of the current descriptor was transmitted |
| timeout_lim | input | TO_W | Wait limit per phase, in cycles |
| ffe_preset_in | input | PRESET_W | Equalizer preset from the active link |
| lfps_tx | output | 1 | Send LFPS burst |
| ts_valid | output | 1 | A training-sequence descriptor is being sent |
| ts_kind | output | 2 | 0 to 3 for TS1 to TS4 |
| ts_cnt | output | CNT_W | Counter field of the descriptor |
| ts_last | output | 1 | Indication: final TS4 (counter at Fh) |
| in_cl0 | output | 1 | Controller in CL0 |
| fec_en | output | 1 | FEC encoder enable |
| scr_en | output | 1 | Scrambler enable |
| precode_en | output | 1 | Pre-coding enable |
| exit_rej | output | 1 | One-cycle pulse: exit request refused |
| exit_err | output | 1 | One-cycle pulse: phase wait timed out |
| tx_preset | output | PRESET_W | Equalizer preset in use |

## Verification
The hardest situations to reach from the ports are the timeout fallback in a wait state deep in the sequence, and wrong phase codes that arrive while the controller waits for the right one. Each wake run picks at random whether a timeout happens and at which of the four phases it falls. In that phase no code is sent, and the bench counts cycles from entry until `exit_err` appears. In the other phases, random runs of foreign codes and stray `ts_sent` pulses are mixed into the gaps before the expected code, and the descriptor is checked to stay put. The preset input is changed throughout the exit to show that `tx_preset` does not move.

// File: rtl/cl0s_wake_pkg.sv
`timescale 1ns/1ps
package cl0s_wake_pkg;

    typedef enum logic [2:0] {
        WK_CL0   = 3'd0,
        WK_CL0S  = 3'd1,
        WK_LFPS  = 3'd2,
        WK_WAIT0 = 3'd3,
        WK_TS1   = 3'd4,
        WK_TS2   = 3'd5,
        WK_TS3   = 3'd6,
        WK_TS4   = 3'd7
    } wk_state_e;

    typedef enum logic [1:0] {
        TSK_1 = 2'd0,
        TSK_2 = 2'd1,
        TSK_3 = 2'd2,
        TSK_4 = 2'd3
    } ts_kind_e;

    localparam int N_PHASE  = 4;
    localparam int PHASE_W  = 4;

    // Descriptor leaving the controller toward the symbol layer
    typedef struct packed {
        logic     valid;
        ts_kind_e kind;
        logic     last;
    } ts_desc_t;

    // Partner phase codes in arrival order: {high trit, low trit}
    function automatic logic [PHASE_W-1:0] phase_code(input int idx);
        case (idx)
            0:       return 4'h0;  // 00t
            1:       return 4'h1;  // 01t
            2:       return 4'h2;  // 02t
            default: return 4'h4;  // 10t
        endcase
    endfunction

    // True in states that wait for a partner phase
    function automatic logic is_waiting(input wk_state_e s);
        return (s == WK_WAIT0) || (s == WK_TS1) || (s == WK_TS2) || (s == WK_TS3);
    endfunction

    // Index of the phase expected in a waiting state
    function automatic logic [1:0] wait_idx(input wk_state_e s);
        case (s)
            WK_TS1:  return 2'd1;
            WK_TS2:  return 2'd2;
            WK_TS3:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // Descriptor kind sent in a state
    function automatic ts_kind_e state_kind(input wk_state_e s);
        case (s)
            WK_TS2:  return TSK_2;
            WK_TS3:  return TSK_3;
            WK_TS4:  return TSK_4;
            default: return TSK_1;
        endcase
    endfunction

    function automatic logic sends_ts(input wk_state_e s);
        return (s == WK_TS1) || (s == WK_TS2) || (s == WK_TS3) || (s == WK_TS4);
    endfunction

endpackage

// File: rtl/cl0s_phase_match.sv
`timescale 1ns/1ps
module cl0s_phase_match
    import cl0s_wake_pkg::*;
#(
    parameter int N = N_PHASE
) (
    input  logic               valid,
    input  logic [PHASE_W-1:0] code,
    output logic [N-1:0]       hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = valid && (code == phase_code(i));
    end
endmodule

// File: rtl/cl0s_dwell_timer.sv
`timescale 1ns/1ps
module cl0s_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cyc
);
    logic [W-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cyc_q <= '0;
        end else if (cyc_q != {W{1'b1}}) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign cyc = cyc_q;
endmodule

// File: rtl/cl0s_ts4_counter.sv
`timescale 1ns/1ps
module cl0s_ts4_counter #(
    parameter int CNT_W = 8,
    parameter int INIT  = 19,
    parameter int FINAL = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             at_final
);
    localparam logic [CNT_W-1:0] INIT_V  = CNT_W'(INIT);
    localparam logic [CNT_W-1:0] FINAL_V = CNT_W'(FINAL);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= INIT_V;
        end else if (load) begin
            cnt_q <= INIT_V;
        end else if (dec && (cnt_q != FINAL_V)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt      = cnt_q;
    assign at_final = (cnt_q == FINAL_V);
endmodule

// File: rtl/cl0s_wake_ctrl.sv
`timescale 1ns/1ps
module cl0s_wake_ctrl
    import cl0s_wake_pkg::*;
#(
    parameter int TO_W      = 8,
    parameter int LFPS_LEN  = 8,
    parameter int CNT_W     = 8,
    parameter int TS4_START = 19,
    parameter int PRESET_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lp_enter,
    input  logic                lp_enter_own,
    input  logic                exit_req,
    input  logic                phase_valid,
    input  logic [3:0]          phase_code,
    input  logic                ts_sent,
    input  logic [TO_W-1:0]     timeout_lim,
    input  logic [PRESET_W-1:0] ffe_preset_in,
    output logic                lfps_tx,
    output logic                ts_valid,
    output logic [1:0]          ts_kind,
    output logic [CNT_W-1:0]    ts_cnt,
    output logic                ts_last,
    output logic                in_cl0,
    output logic                fec_en,
    output logic                scr_en,
    output logic                precode_en,
    output logic                exit_rej,
    output logic                exit_err,
    output logic [PRESET_W-1:0] tx_preset
);
    localparam int               TS4_FINAL = 15;
    localparam logic [TO_W-1:0]  LFPS_LAST = TO_W'(LFPS_LEN - 1);

    wk_state_e           state_q, state_d;
    logic                own_q;
    logic                rej_q, err_q;
    logic [PRESET_W-1:0] preset_q;

    logic [N_PHASE-1:0]  hit;
    logic [TO_W-1:0]     cyc;
    logic                adv, tmo, lfps_end, done;
    logic                ts4_load, ts4_dec, ts4_final;
    logic [CNT_W-1:0]    ts4_cnt;
    ts_desc_t            desc;

    cl0s_phase_match #(.N(N_PHASE)) i_match (
        .valid (phase_valid),
        .code  (phase_code),
        .hit   (hit)
    );

    cl0s_dwell_timer #(.W(TO_W)) i_dwell (
        .clk (clk),
        .rst (rst),
        .clr (state_d != state_q),
        .cyc (cyc)
    );

    cl0s_ts4_counter #(.CNT_W(CNT_W), .INIT(TS4_START), .FINAL(TS4_FINAL)) i_ts4 (
        .clk      (clk),
        .rst      (rst),
        .load     (ts4_load),
        .dec      (ts4_dec),
        .cnt      (ts4_cnt),
        .at_final (ts4_final)
    );

    // Advance only on the one phase expected in the current wait state
    assign adv      = is_waiting(state_q) && hit[wait_idx(state_q)];
    assign tmo      = is_waiting(state_q) && !adv && (cyc == timeout_lim);
    assign lfps_end = (state_q == WK_LFPS) && (cyc == LFPS_LAST);
    assign ts4_load = (state_q == WK_TS3) && adv;
    assign ts4_dec  = (state_q == WK_TS4) && ts_sent && !ts4_final;
    assign done     = (state_q == WK_TS4) && ts_sent && ts4_final;

    always_comb begin
        state_d = state_q;
        case (state_q)
            WK_CL0:   if (lp_enter)            state_d = WK_CL0S;
            WK_CL0S:  if (exit_req && own_q)   state_d = WK_LFPS;
            WK_LFPS:  if (lfps_end)            state_d = WK_WAIT0;
            WK_WAIT0: if (adv)                 state_d = WK_TS1;
                      else if (tmo)            state_d = WK_CL0S;
            WK_TS1:   if (adv)                 state_d = WK_TS2;
                      else if (tmo)            state_d = WK_CL0S;
            WK_TS2:   if (adv)                 state_d = WK_TS3;
                      else if (tmo)            state_d = WK_CL0S;
            WK_TS3:   if (adv)                 state_d = WK_TS4;
                      else if (tmo)            state_d = WK_CL0S;
            WK_TS4:   if (done)                state_d = WK_CL0;
            default:                           state_d = WK_CL0S;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WK_CL0;
            own_q    <= 1'b0;
            rej_q    <= 1'b0;
            err_q    <= 1'b0;
            preset_q <= '0;
        end else begin
            state_q <= state_d;
            rej_q   <= (state_q == WK_CL0S) && exit_req && !own_q;
            err_q   <= tmo;
            if ((state_q == WK_CL0) && lp_enter) begin
                own_q <= lp_enter_own;
            end
            // Preset follows the active link, frozen outside CL0
            if (state_q == WK_CL0) begin
                preset_q <= ffe_preset_in;
            end
        end
    end

    always_comb begin
        desc.valid = sends_ts(state_q);
        desc.kind  = state_kind(state_q);
        desc.last  = (state_q == WK_TS4) && ts4_final;
    end

    assign lfps_tx    = (state_q == WK_LFPS);
    assign ts_valid   = desc.valid;
    assign ts_kind    = desc.valid ? desc.kind : 2'd0;
    assign ts_cnt     = (state_q == WK_TS4) ? ts4_cnt : '0;
    assign ts_last    = desc.last;
    assign in_cl0     = (state_q == WK_CL0);
    assign fec_en     = in_cl0;
    assign scr_en     = in_cl0;
    assign precode_en = in_cl0;
    assign exit_rej   = rej_q;
    assign exit_err   = err_q;
    assign tx_preset  = preset_q;
endmodule

// File: rtl/cl0s_wake_chk.sv
`timescale 1ns/1ps
module cl0s_wake_chk #(
    parameter int CNT_W    = 8,
    parameter int PRESET_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                exit_req,
    input logic                ts_sent,
    input logic                lfps_tx,
    input logic                ts_valid,
    input logic [1:0]          ts_kind,
    input logic [CNT_W-1:0]    ts_cnt,
    input logic                ts_last,
    input logic                in_cl0,
    input logic                fec_en,
    input logic                scr_en,
    input logic                precode_en,
    input logic                exit_rej,
    input logic                exit_err,
    input logic [PRESET_W-1:0] tx_preset
);
    // R2
    enables_off_chk: assert property (@(posedge clk) disable iff (rst)
        (lfps_tx || ts_valid) |-> (!fec_en && !scr_en && !precode_en));

    // R4
    lfps_ts_excl_chk: assert property (@(posedge clk) disable iff (rst)
        lfps_tx |-> !ts_valid);

    // R3
    rej_cause_chk: assert property (@(posedge clk) disable iff (rst)
        exit_rej |-> ($past(exit_req) && !lfps_tx && !in_cl0));

    // R5
    ts_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ts_valid && !$past(ts_valid)) |-> (ts_kind == 2'd0));

    // R5
    kind_order_chk: assert property (@(posedge clk) disable iff (rst)
        (ts_valid && $past(ts_valid) && (ts_kind != $past(ts_kind)))
            |-> (ts_kind == $past(ts_kind) + 2'd1));

    // R7
    ts4_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (ts_valid && (ts_kind == 2'd3)
            && $past(ts_valid && (ts_kind == 2'd3) && ts_sent && !ts_last))
            |-> (ts_cnt == $past(ts_cnt) - 1'b1));

    // R8
    cl0_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_cl0) |-> $past(ts_last && ts_sent));

    // R9
    err_outside_chk: assert property (@(posedge clk) disable iff (rst)
        exit_err |-> (!in_cl0 && !ts_valid && !lfps_tx));

    // R10
    preset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_cl0 && !$past(in_cl0)) |-> $stable(tx_preset));
endmodule

bind cl0s_wake_ctrl cl0s_wake_chk #(.CNT_W(CNT_W), .PRESET_W(PRESET_W)) i_wake_chk (.*);

// File: tb/test_cl0s_wake_ctrl.sv
`timescale 1ns/1ps
module test_cl0s_wake_ctrl;
    localparam int TO_W      = 8;
    localparam int LFPS_LEN  = 8;
    localparam int CNT_W     = 8;
    localparam int TS4_START = 19;
    localparam int PRESET_W  = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                lp_enter = 1'b0, lp_enter_own = 1'b0, exit_req = 1'b0;
    logic                phase_valid = 1'b0, ts_sent = 1'b0;
    logic [3:0]          phase_code = 4'h0;
    logic [TO_W-1:0]     timeout_lim = 8'd10;
    logic [PRESET_W-1:0] ffe_preset_in = '0;
    logic                lfps_tx, ts_valid, ts_last, in_cl0;
    logic                fec_en, scr_en, precode_en, exit_rej, exit_err;
    logic [1:0]          ts_kind;
    logic [CNT_W-1:0]    ts_cnt;
    logic [PRESET_W-1:0] tx_preset;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cl0s_wake_ctrl #(
        .TO_W(TO_W), .LFPS_LEN(LFPS_LEN), .CNT_W(CNT_W),
        .TS4_START(TS4_START), .PRESET_W(PRESET_W)
    ) i_cl0s_wake_ctrl (
        .clk(clk), .rst(rst), .lp_enter(lp_enter), .lp_enter_own(lp_enter_own),
        .exit_req(exit_req), .phase_valid(phase_valid), .phase_code(phase_code),
        .ts_sent(ts_sent), .timeout_lim(timeout_lim), .ffe_preset_in(ffe_preset_in),
        .lfps_tx(lfps_tx), .ts_valid(ts_valid), .ts_kind(ts_kind), .ts_cnt(ts_cnt),
        .ts_last(ts_last), .in_cl0(in_cl0), .fec_en(fec_en), .scr_en(scr_en),
        .precode_en(precode_en), .exit_rej(exit_rej), .exit_err(exit_err),
        .tx_preset(tx_preset)
    );

    function automatic logic [3:0] exp_code(input int k);
        case (k)
            0:       return 4'h0;
            1:       return 4'h1;
            2:       return 4'h2;
            default: return 4'h4;
        endcase
    endfunction

    function automatic int exp_ts4(input int n);
        return TS4_START - n;
    endfunction

    function automatic logic [3:0] pick_junk(input int k);
        logic [3:0] r;
        r = 4'($urandom_range(0, 15));
        if (r == exp_code(k)) r = r ^ 4'h8;
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        lp_enter = 1'b0; exit_req = 1'b0; phase_valid = 1'b0; ts_sent = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 in_cl0", int'(in_cl0), 1);
        chk("R1 fec_en", int'(fec_en), 1);
        chk("R1 scr_en", int'(scr_en), 1);
        chk("R1 precode_en", int'(precode_en), 1);
        chk("R1 lfps_tx", int'(lfps_tx), 0);
        chk("R1 ts_valid", int'(ts_valid), 0);
        chk("R1 exit_rej", int'(exit_rej), 0);
        chk("R1 exit_err", int'(exit_err), 0);
    endtask

    task automatic run_exit(input bit own, input int tmo_at, input int lim);
        logic [PRESET_W-1:0] kept;
        int m;
        int n;
        bit fin;
        timeout_lim = TO_W'(lim);
        kept = PRESET_W'($urandom_range(0, 15));
        ffe_preset_in = kept;
        lp_enter = 1'b1; lp_enter_own = own;
        tick();
        lp_enter = 1'b0;
        chk("R2 in_cl0 after entry", int'(in_cl0), 0);
        chk("R2 fec_en off", int'(fec_en), 0);
        chk("R2 scr_en off", int'(scr_en), 0);
        chk("R2 precode_en off", int'(precode_en), 0);
        ffe_preset_in = PRESET_W'($urandom_range(0, 15));
        exit_req = 1'b1;
        tick();
        exit_req = 1'b0;
        if (!own) begin
            chk("R3 exit_rej pulse", int'(exit_rej), 1);
            chk("R3 no lfps", int'(lfps_tx), 0);
            tick();
            chk("R3 exit_rej one cycle", int'(exit_rej), 0);
            chk("R3 no lfps later", int'(lfps_tx), 0);
            chk("R3 stays out of CL0", int'(in_cl0), 0);
            chk("R10 preset held", int'(tx_preset), int'(kept));
            do_reset();
            return;
        end
        for (int i = 0; i < LFPS_LEN; i++) begin
            chk("R4 lfps high", int'(lfps_tx), 1);
            chk("R4 no ts during lfps", int'(ts_valid), 0);
            chk("R2 enables off in lfps", int'(fec_en), 0);
            if ((i % 3) == 1) begin
                phase_valid = 1'b1; phase_code = 4'h0;   // early phase, ignored (R6)
            end
            tick();
            phase_valid = 1'b0;
        end
        chk("R4 lfps ends", int'(lfps_tx), 0);
        chk("R6 early phase ignored", int'(ts_valid), 0);
        for (int k = 0; k < 4; k++) begin
            if (k == tmo_at) begin
                m = 0;
                while (!exit_err && m < 100) begin
                    ffe_preset_in = PRESET_W'($urandom_range(0, 15));
                    tick();
                    m++;
                end
                chk("R9 timeout latency", m, lim + 1);
                chk("R9 back in CL0s", int'(in_cl0), 0);
                chk("R9 no ts", int'(ts_valid), 0);
                chk("R9 no lfps", int'(lfps_tx), 0);
                chk("R10 preset held", int'(tx_preset), int'(kept));
                tick();
                chk("R9 err one cycle", int'(exit_err), 0);
                do_reset();
                return;
            end
            for (int j = 0; j < $urandom_range(0, 3); j++) begin
                phase_valid = 1'($urandom_range(0, 1));
                phase_code  = pick_junk(k);
                ts_sent     = 1'($urandom_range(0, 1));
                tick();
                phase_valid = 1'b0; ts_sent = 1'b0;
                chk("R6 junk keeps ts_valid", int'(ts_valid), (k > 0) ? 1 : 0);
                if (k > 0) chk("R6 junk keeps kind", int'(ts_kind), k - 1);
            end
            phase_valid = 1'b1;
            phase_code  = exp_code(k);
            tick();
            phase_valid = 1'b0;
            chk("R5 ts_valid", int'(ts_valid), 1);
            chk("R5 ts_kind", int'(ts_kind), k);
            chk("R7 counter field", int'(ts_cnt), (k == 3) ? TS4_START : 0);
            chk("R10 preset held", int'(tx_preset), int'(kept));
            ffe_preset_in = PRESET_W'($urandom_range(0, 15));
        end
        n = 0;
        fin = 1'b0;
        for (int s = 0; s < 64 && !fin; s++) begin
            for (int j = 0; j < $urandom_range(0, 2); j++) begin
                phase_valid = 1'($urandom_range(0, 1));
                phase_code  = 4'($urandom_range(0, 15));
                tick();
                phase_valid = 1'b0;
                chk("R6 TS4 ignores phases", int'(ts_kind), 3);
            end
            chk("R7 ts4 count", int'(ts_cnt), exp_ts4(n));
            chk("R7 indication", int'(ts_last), (exp_ts4(n) == 15) ? 1 : 0);
            ts_sent = 1'b1;
            tick();
            ts_sent = 1'b0;
            if (exp_ts4(n) == 15) begin
                fin = 1'b1;
                chk("R8 in_cl0", int'(in_cl0), 1);
                chk("R8 ts_valid off", int'(ts_valid), 0);
                chk("R8 fec_en", int'(fec_en), 1);
                chk("R8 scr_en", int'(scr_en), 1);
                chk("R8 precode_en", int'(precode_en), 1);
                chk("R10 preset kept at CL0", int'(tx_preset), int'(kept));
            end else begin
                n++;
                chk("R8 not yet CL0", int'(in_cl0), 0);
            end
        end
        ffe_preset_in = PRESET_W'($urandom_range(0, 15));
        kept = ffe_preset_in;
        tick();
        chk("R10 preset tracks in CL0", int'(tx_preset), int'(kept));
    endtask

    initial begin
        int seed_dummy;
        bit own;
        int tmo_at;
        seed_dummy = int'($urandom(32'd4242));
        do_reset();
        for (int it = 0; it < 40; it++) begin
            if (it == 1)      own = 1'b0;
            else if (it < 3)  own = 1'b1;
            else              own = ($urandom_range(0, 5) != 0);
            if (it == 2)      tmo_at = 0;
            else if (it == 3) tmo_at = 3;
            else if (it < 3)  tmo_at = 4;
            else              tmo_at = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : 4;
            run_exit(own, tmo_at, $urandom_range(10, 20));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule